// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Break Handling

The block receives asynchronous serial frames on a single input line. A base-clock enable, pulsed by a rate generator elsewhere on the chip, steps the receiver at 16, 8 or 4 ticks per bit. The line passes through a two-flop synchroniser. The receiver starts a frame when it finds the line low while idle, then samples each bit once in the middle of its bit period. Each completed frame is offered to a receive FIFO on a valid/ready push port, together with that frame's parity and framing error bits.

Sticky error flags record parity errors, framing errors and line breaks. A line break is a frame in which every sampled bit, the stop bit included, is 0. A break suspends pushes into the FIFO, but reception keeps running. If the line stays low, every further frame raises the break and framing flags again. Pushes resume once software has cleared the break flag and a frame has arrived whose stop bit is 1.

A small transmit gate sits beside the receiver. When transmit enable is low, the transmitter core is held idle and the outgoing line shows the idle (mark) level, both in the same cycle.

Push port back-pressure: `push_valid` stays high and the pushed word stays stable until a cycle in which `push_ready` is high. While a word is waiting, nothing new can be loaded. A frame that completes while the earlier word is still waiting is discarded. If the frame completes in the same cycle that the waiting word is accepted, the new frame is loaded.

Top module: `serial_rx_break`

## Requirements
- R1: `ratio_sel` picks ticks per bit: 2'b00 gives 16, 2'b01 gives 8, 2'b10 and 2'b11 give 4. The receiver counts the tick that detects a low line as pulse 1 and samples each bit on pulse 8, 4 or 2 of that bit.
- R2: A frame is a start bit (0), DATA_BITS data bits sent LSB first, a parity bit when `par_en` is 1, and one stop bit. A valid frame appears on `push_data` with `push_valid` high.
- R3: If the start bit samples as 1 at its mid-point, the frame is dropped and the receiver goes back to idle. Nothing is pushed and no flag changes.
- R4: A stop bit sampled as 0 sets `fer_flag`. If the frame is not a break, its data is still pushed, with `push_fer` set to 1.
- R5: With `par_en` = 1, parity is even when `par_odd` = 0: the data bits plus the parity bit hold an even number of ones. When `par_odd` = 1 they hold an odd number. A mismatch sets `per_flag` and `push_per`, and the data is still pushed.
- R6: A frame whose data bits, parity bit and stop bit are all 0 sets `brk_flag` and `fer_flag`, and is not pushed.
- R7: While the line is held low, the receiver starts a new frame after each stop bit. If `fer_flag` and `brk_flag` are cleared during the break, the next frame sets them again.
- R8: After a break, no frame is pushed until `brk_flag` has been cleared and a frame with a stop bit of 1 has completed. That frame is pushed.
- R9: `per_flag`, `fer_flag` and `brk_flag` stay set until their clear input is pulsed. When a set and a clear fall in the same cycle, the set wins.
- R10: While `rx_en` is 0, no frame is received and no push occurs. All three flags keep their values.
- R11: When a word is waiting on the push port and `push_ready` is low, `push_valid` stays high and the word stays stable. A frame that completes during the wait is discarded.
- R12: When `tx_en` is 0, `txd` = 1 and `tx_run` = 0 in that same cycle. When `tx_en` is 1, `txd` follows `tx_ser` and `tx_run` = 1.
- R13: After reset, `push_valid` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Base-clock enable, one pulse per oversample tick |
| rx_in | input | 1 | Serial receive line (asynchronous) |
| ratio_sel | input | 2 | Ticks-per-bit select |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| tx_ser | input | 1 | Serial bit from the transmitter core |
| push_valid | output | 1 | FIFO push request |
| push_ready | input | 1 | FIFO can accept the word |
| push_data | output | DATA_BITS | Received data |
| push_per | output | 1 | Parity error of the pushed frame |
| push_fer | output | 1 | Framing error of the pushed frame |
| per_flag | output | 1 | Sticky parity error flag |
| fer_flag | output | 1 | Sticky framing error flag |
| brk_flag | output | 1 | Sticky line-break flag |
| per_clr | input | 1 | Clears `per_flag` |
| fer_clr | input | 1 | Clears `fer_flag` |
| brk_clr | input | 1 | Clears `brk_flag` |
| txd | output | 1 | Outgoing serial line |
| tx_run | output | 1 | Run enable to the transmitter core |

## Verification
The bench holds the line low across several frame times and clears the flags in the middle of the break. A receiver that waits for a fresh falling edge would leave the flags cleared, and one that pushes break frames would fill the FIFO with zeros. The bench then sends a good frame before the break flag is cleared and another one after it. Unlocking too early, or never, shows up as a missing or an extra push. A short low pulse checks glitch rejection: a receiver without it would push a frame of ones. Random bytes are sent at all three ratios, with sparse ticks and injected parity errors, which exposes an off-by-one in the mid-bit pulse count or a wrong parity sense. Two unaccepted frames in a row check that the waiting word is neither overwritten nor lost.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  localparam int CNT_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_TAIL
  } rx_state_e;

  // ticks per bit for a ratio selection code
  function automatic logic [CNT_W-1:0] ratio_len(input logic [1:0] sel);
    case (sel)
      2'b00:   ratio_len = CNT_W'(16);
      2'b01:   ratio_len = CNT_W'(8);
      default: ratio_len = CNT_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxb_frame.sv
module rxb_frame
  import rxb_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 rx_i,
  input  logic                 en_i,
  input  logic [1:0]           ratio_i,
  input  logic                 par_en_i,
  input  logic                 par_odd_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 per_o,
  output logic                 fer_o,
  output logic                 brk_o
);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  rx_state_e            state_q;
  logic [CNT_W-1:0]     pos_q, len_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] shreg_q;
  logic                 par_acc_q, zero_q;
  logic [CNT_W-1:0]     half_m1, last_pos;
  logic                 at_mid, at_last;

  assign half_m1  = (len_q >> 1) - CNT_W'(1);
  assign last_pos = len_q - CNT_W'(1);
  assign at_mid   = (pos_q == half_m1);
  assign at_last  = (pos_q == last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pos_q     <= '0;
      len_q     <= CNT_W'(16);
      idx_q     <= '0;
      shreg_q   <= '0;
      par_acc_q <= 1'b0;
      zero_q    <= 1'b1;
      done_o    <= 1'b0;
      data_o    <= '0;
      per_o     <= 1'b0;
      fer_o     <= 1'b0;
      brk_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (tick_i) begin
        if (state_q != ST_IDLE) pos_q <= at_last ? '0 : pos_q + CNT_W'(1);
        case (state_q)
          ST_IDLE: begin
            if (!rx_i) begin
              // this tick is pulse 1 of the start bit
              state_q   <= ST_START;
              pos_q     <= CNT_W'(1);
              len_q     <= ratio_len(ratio_i);
              idx_q     <= '0;
              par_acc_q <= 1'b0;
              zero_q    <= 1'b1;
            end
          end
          ST_START: begin
            if (at_mid && rx_i) state_q <= ST_IDLE;
            else if (at_last)   state_q <= ST_DATA;
          end
          ST_DATA: begin
            if (at_mid) begin
              shreg_q   <= {rx_i, shreg_q[DATA_BITS-1:1]};
              par_acc_q <= par_acc_q ^ rx_i;
              if (rx_i) zero_q <= 1'b0;
            end
            if (at_last) begin
              if (idx_q == IDX_W'(DATA_BITS-1)) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else                             idx_q   <= idx_q + IDX_W'(1);
            end
          end
          ST_PAR: begin
            if (at_mid) begin
              par_acc_q <= par_acc_q ^ rx_i;
              if (rx_i) zero_q <= 1'b0;
            end
            if (at_last) state_q <= ST_STOP;
          end
          ST_STOP: begin
            if (at_mid) begin
              done_o  <= 1'b1;
              data_o  <= shreg_q;
              fer_o   <= !rx_i;
              per_o   <= par_en_i && (par_acc_q != par_odd_i);
              brk_o   <= !rx_i && zero_q;
              state_q <= ST_TAIL;
            end
          end
          ST_TAIL: begin
            if (at_last) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_glitch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && state_q == ST_START && at_mid && rx_i) |=> (state_q == ST_IDLE));

  assert_re_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (state_q == ST_IDLE && !done_o));
endmodule

// File: rtl/rxb_flags.sv
module rxb_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic per_i,
  input  logic fer_i,
  input  logic brk_i,
  input  logic per_clr_i,
  input  logic fer_clr_i,
  input  logic brk_clr_i,
  output logic per_o,
  output logic fer_o,
  output logic brk_o,
  output logic push_o
);
  logic lock_q, lock_nxt, brk_left;

  // break flag as it stands after this cycle's clear
  assign brk_left = brk_o & ~brk_clr_i;
  assign lock_nxt = brk_i | (lock_q & ~(~brk_left & ~fer_i));
  assign push_o   = done_i & ~lock_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_o  <= 1'b0;
      fer_o  <= 1'b0;
      brk_o  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      per_o <= (per_o & ~per_clr_i) | (done_i & per_i);
      fer_o <= (fer_o & ~fer_clr_i) | (done_i & fer_i);
      brk_o <= (brk_o & ~brk_clr_i) | (done_i & brk_i);
      if (done_i) lock_q <= lock_nxt;
    end
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fer_o && !fer_clr_i) |=> fer_o);

  assert_brk_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && brk_i) |=> (brk_o && fer_o));

  assert_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && brk_o && !brk_clr_i) |-> !push_o);
endmodule

// File: rtl/rxb_push.sv
module rxb_push #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 per_i,
  input  logic                 fer_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 per_o,
  output logic                 fer_o
);
  logic slot_free;
  assign slot_free = !valid_o || ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      per_o   <= 1'b0;
      fer_o   <= 1'b0;
    end else if (load_i && slot_free) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      per_o   <= per_i;
      fer_o   <= fer_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(fer_o)));
endmodule

// File: rtl/serial_rx_break.sv
module serial_rx_break #(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 rx_in,
  input  logic [1:0]           ratio_sel,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 rx_en,
  input  logic                 tx_en,
  input  logic                 tx_ser,
  output logic                 push_valid,
  input  logic                 push_ready,
  output logic [DATA_BITS-1:0] push_data,
  output logic                 push_per,
  output logic                 push_fer,
  output logic                 per_flag,
  output logic                 fer_flag,
  output logic                 brk_flag,
  input  logic                 per_clr,
  input  logic                 fer_clr,
  input  logic                 brk_clr,
  output logic                 txd,
  output logic                 tx_run
);
  logic                 rx_s;
  logic                 f_done, f_per, f_fer, f_brk, do_push;
  logic [DATA_BITS-1:0] f_data;

  rxb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_in), .q_o(rx_s)
  );

  rxb_frame #(.DATA_BITS(DATA_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .rx_i(rx_s), .en_i(rx_en),
    .ratio_i(ratio_sel), .par_en_i(par_en), .par_odd_i(par_odd),
    .done_o(f_done), .data_o(f_data), .per_o(f_per), .fer_o(f_fer), .brk_o(f_brk)
  );

  rxb_flags u_flags (
    .clk(clk), .rst_n(rst_n), .done_i(f_done), .per_i(f_per), .fer_i(f_fer),
    .brk_i(f_brk), .per_clr_i(per_clr), .fer_clr_i(fer_clr), .brk_clr_i(brk_clr),
    .per_o(per_flag), .fer_o(fer_flag), .brk_o(brk_flag), .push_o(do_push)
  );

  rxb_push #(.DATA_BITS(DATA_BITS)) u_push (
    .clk(clk), .rst_n(rst_n), .load_i(do_push), .data_i(f_data), .per_i(f_per),
    .fer_i(f_fer), .ready_i(push_ready), .valid_o(push_valid), .data_o(push_data),
    .per_o(push_per), .fer_o(push_fer)
  );

  // transmit gate: disabling forces mark level and holds the core idle
  assign tx_run = tx_en;
  assign txd    = tx_en ? tx_ser : 1'b1;
endmodule

// File: tb/serial_rx_break_test.sv
module serial_rx_break_test;
  localparam int CLK_PERIOD = 10;
  localparam int DB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1, rx_in = 1'b1;
  logic [1:0] ratio_sel = 2'b00;
  logic par_en = 1'b0, par_odd = 1'b0, rx_en = 1'b1, tx_en = 1'b0, tx_ser = 1'b0;
  logic push_ready = 1'b0, per_clr = 1'b0, fer_clr = 1'b0, brk_clr = 1'b0;
  logic push_valid, push_per, push_fer, per_flag, fer_flag, brk_flag, txd, tx_run;
  logic [DB-1:0] push_data;

  int checks = 0, failures = 0, gap = 1;
  bit finished = 0;

  serial_rx_break #(.DATA_BITS(DB)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_in(rx_in), .ratio_sel(ratio_sel),
    .par_en(par_en), .par_odd(par_odd), .rx_en(rx_en), .tx_en(tx_en), .tx_ser(tx_ser),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .push_per(push_per), .push_fer(push_fer), .per_flag(per_flag), .fer_flag(fer_flag),
    .brk_flag(brk_flag), .per_clr(per_clr), .fer_clr(fer_clr), .brk_clr(brk_clr),
    .txd(txd), .tx_run(tx_run)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ticks_per_bit(input logic [1:0] sel);
    return (sel == 2'b00) ? 16 : (sel == 2'b01) ? 8 : 4;
  endfunction

  function automatic logic parity_bit(input logic [DB-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      repeat (gap - 1) begin @(negedge clk); tick_en = 1'b0; end
      @(negedge clk); tick_en = 1'b1;
    end
  endtask

  task automatic send_frame(input logic [DB-1:0] d, input logic badp, input logic stopv);
    int os;
    os = ticks_per_bit(ratio_sel);
    rx_in = 1'b0; ticks(os);
    for (int i = 0; i < DB; i++) begin rx_in = d[i]; ticks(os); end
    if (par_en) begin rx_in = parity_bit(d, par_odd) ^ badp; ticks(os); end
    rx_in = stopv; ticks(os);
    rx_in = 1'b1; ticks(2 * os);
  endtask

  task automatic accept();
    @(negedge clk); push_ready = 1'b1;
    @(negedge clk); push_ready = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk); per_clr = 1'b1; fer_clr = 1'b1; brk_clr = 1'b1;
    ticks(1);
    per_clr = 1'b0; fer_clr = 1'b0; brk_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DB-1:0] d, first;
    logic bp;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R13 push_valid", push_valid, 0);
    check("R13 flags", {per_flag, fer_flag, brk_flag}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 transmit gate
    tx_en = 1'b1; tx_ser = 1'b0; #1;
    check("R12 txd follows", txd, 0);
    check("R12 run", tx_run, 1);
    tx_en = 1'b0; #1;
    check("R12 txd mark", txd, 1);
    check("R12 idle", tx_run, 0);

    // R2 basic frame at 16x
    send_frame(8'hA5, 1'b0, 1'b1);
    check("R2 valid", push_valid, 1);
    check("R2 data", push_data, 8'hA5);
    check("R2 no fer", push_fer, 0);
    accept();
    check("R11 valid drops after accept", push_valid, 0);

    // R1/R5 random frames over all ratios, sparse ticks on some
    for (int k = 0; k < 24; k++) begin
      ratio_sel = 2'($urandom_range(0, 3));
      gap = ($urandom_range(0, 3) == 0) ? 3 : 1;
      par_en = 1'($urandom_range(0, 1));
      par_odd = 1'($urandom_range(0, 1));
      d = 8'($urandom_range(1, 255));
      bp = par_en && ($urandom_range(0, 3) == 0);
      send_frame(d, bp, 1'b1);
      check("R1 valid", push_valid, 1);
      check("R1 data", push_data, d);
      check("R5 push_per", push_per, bp);
      check("R5 per_flag", per_flag, bp);
      accept();
      clear_all();
    end
    gap = 1; par_en = 1'b0; ratio_sel = 2'b00;

    // R3 start glitch
    rx_in = 1'b0; ticks(3); rx_in = 1'b1; ticks(40);
    check("R3 no push", push_valid, 0);
    check("R3 no flags", {per_flag, fer_flag, brk_flag}, 0);
    send_frame(8'h3C, 1'b0, 1'b1);
    check("R3 next frame ok", push_data, 8'h3C);
    accept();

    // R4 framing error, data still pushed
    send_frame(8'h5A, 1'b0, 1'b0);
    check("R4 fer_flag", fer_flag, 1);
    check("R4 push_fer", push_fer, 1);
    check("R4 data", push_data, 8'h5A);
    check("R4 not break", brk_flag, 0);
    accept();

    // R10 receiver disabled: nothing received, flags kept
    rx_en = 1'b0;
    send_frame(8'h11, 1'b0, 1'b1);
    check("R10 no push", push_valid, 0);
    check("R10 fer kept", fer_flag, 1);
    rx_en = 1'b1;
    clear_all();
    check("R9 cleared", fer_flag, 0);

    // R11 back-pressure
    send_frame(8'h81, 1'b0, 1'b1);
    first = push_data;
    send_frame(8'h42, 1'b0, 1'b1);
    check("R11 held", push_valid, 1);
    check("R11 first word kept", push_data, 8'h81);
    accept();
    check("R11 second dropped", push_valid, 0);

    // R6/R7 line held low
    rx_in = 1'b0; ticks(164);
    check("R6 brk", brk_flag, 1);
    check("R6 fer", fer_flag, 1);
    check("R6 no push", push_valid, 0);
    clear_all();
    check("R7 cleared", {fer_flag, brk_flag}, 0);
    ticks(164);
    check("R7 brk again", brk_flag, 1);
    check("R7 fer again", fer_flag, 1);
    rx_in = 1'b1; ticks(500);
    check("R8 still no push", push_valid, 0);
    send_frame(8'h77, 1'b0, 1'b1);
    check("R8 locked while brk set", push_valid, 0);
    clear_all();
    send_frame(8'h9E, 1'b0, 1'b1);
    check("R8 resumed valid", push_valid, 1);
    check("R8 resumed data", push_data, 8'h9E);
    accept();

    finished = 1;
    summary();
    $finish;
  end
endmodule